// File: doc/BRIEF.md
# Transmit Byte Queue with Level Events

This block is the transmit side of a serial port's byte buffer. Software pushes bytes by writing a data register. The serial transmitter takes the oldest byte through a pop handshake. The queue tracks its fill level and shows full and empty flags in a status word. A FIFO status word reports the transmit fill level next to a receive level that another block supplies.

Two event outputs go to the interrupt block:
- A watermark event stays high while the fill level is at or above a programmable threshold.
- An empty event pulses for one cycle when the transmitter drains the last byte.

Software can flush the queue through a FIFO control register, which also holds the threshold codes.

Register accesses use a simple port. A write is one cycle of `reg_we` with an address and 32 data bits. A read is combinational from `reg_raddr`.

Top module: `tx_fifo_wm`

## Requirements
- R1: A write to offset 0x1C pushes bits 7:0 of the write data. While `tx_valid` is high, `tx_byte` shows the oldest stored byte, so bytes leave in the order they were written.
- R2: The queue holds 32 bytes. A push made while the level is 32 is dropped: the level stays at 32 and the stored bytes are unchanged, even if a pop happens in the same cycle.
- R3: Offset 0x14 reads the status word with these bits:
  - bit 0 is TX full (level equals 32);
  - bit 1 reads 0;
  - bit 2 is TX empty (level is 0);
  - bit 3 reads 1;
  - bits 4 and 5 are both 1 when `rx_level` is 0.

  After reset the word reads 0x3C.
- R4: Offset 0x20 is the FIFO control register. Bits 6:5 hold the TX threshold code and bits 4:2 hold the RX threshold code. Both read back as written. Bits 1:0 always read 0, and the register resets to 0.
- R5: A write to 0x20 with bit 1 set empties the queue. The level reads 0 in the next cycle, and this happens even if a pop is requested in the same cycle.
- R6: TX threshold codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 16 bytes. `evt_tx_wm` is high exactly when the current level is at or above the selected threshold.
- R7: `evt_tx_empty` is high for exactly one cycle, in the cycle in which a pop has taken the level from 1 to 0. A flush does not raise it.
- R8: Offset 0x24 reads the TX level modulo 32 in bits 4:0 and `rx_level` in bits 20:16. All other bits read 0.
- R9: A pop happens only when `tx_en` and `tx_pop` are both high and the level is nonzero. When `tx_en` is low, `tx_pop` has no effect.
- R10: A push and a pop in the same cycle, with a level between 1 and 31, leave the level unchanged and keep the byte order.
- R11: Reads of any other offset return 0. Writes to any other offset change neither the level nor the control register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 8 | Register read byte offset |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_level | input | 5 | Receive fill level from the receive side |
| tx_en | input | 1 | Transmit enable |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_valid | output | 1 | Queue holds at least one byte |
| tx_byte | output | 8 | Head byte |
| tx_full | output | 1 | Level equals depth |
| tx_empty | output | 1 | Level is zero |
| evt_tx_wm | output | 1 | Level at or above threshold |
| evt_tx_empty | output | 1 | One-cycle pulse when draining completes |

## Verification
The bench fills the queue to 32 and then pushes once more. A design that wraps its write pointer would overwrite the head byte, and a design that counts past the depth would show a bad level. The bench also combines a push with a pop at full and at mid level. A block that lets the pop make room for the dropped push, or that moves the level on a matched push and pop, fails these checks.

The watermark is checked on both sides of two thresholds. An off-by-one compare shows up one byte early or late. The empty pulse is checked for its single-cycle width and for staying low on a flush, which exposes a pulse decoded from the level alone. The bench also checks that a 32-byte level reads 0 in the 5-bit level field while the full flag is set.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned RXL_W  = 5;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WDATA  = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_FCTRL  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_FSTAT  = 8'h24;

    // Stored part of the FIFO control register
    typedef struct packed {
        logic [1:0] tx_code;
        logic [2:0] rx_code;
    } fctrl_t;

    // Threshold selected by a TX code
    function automatic int unsigned thr_of(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned DATA_W = 8,
    localparam int unsigned AW    = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic              flush,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [LVL_W-1:0]  level,
    output logic [LVL_W-1:0]  level_d
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              push_ok, pop_ok;

    assign push_ok = push && (level != LVL_W'(DEPTH));
    assign pop_ok  = pop && (level != '0);
    assign dout    = mem[rptr];

    always_comb begin
        level_d = level;
        if (flush)
            level_d = '0;
        else if (push_ok && !pop_ok)
            level_d = level + 1'b1;
        else if (pop_ok && !push_ok)
            level_d = level - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush)
            mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            level <= level_d;
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    assert_drop_full_R2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && level == LVL_W'(DEPTH)) |=> level == LVL_W'(DEPTH));

    assert_flush_R5: assert property (@(posedge clk) disable iff (rst)
        flush |=> level == '0);

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !flush && level != '0 && level != LVL_W'(DEPTH)) |=> $stable(level));

endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
    parameter int unsigned LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] level_d,
    input  logic [LVL_W-1:0] thr_d,
    output logic             evt_wm,
    output logic             evt_empty
);
    always_ff @(posedge clk) begin
        if (rst) begin
            evt_wm    <= 1'b0;
            evt_empty <= 1'b0;
        end else begin
            evt_wm    <= (level_d >= thr_d);
            evt_empty <= !flush && (level != '0) && (level_d == '0);
        end
    end

    assert_empty_once_R7: assert property (@(posedge clk) disable iff (rst)
        evt_empty |=> !evt_empty);

endmodule

// File: rtl/txq_regs.sv
module txq_regs
    import txq_pkg::*;
#(
    parameter int unsigned LVL_W = 6,
    parameter int unsigned DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [31:0]       wdata,
    input  logic [ADDR_W-1:0] raddr,
    input  logic [LVL_W-1:0]  level,
    input  logic [RXL_W-1:0]  rx_level,
    output logic [31:0]       rdata,
    output logic              push,
    output logic [DATA_W-1:0] push_byte,
    output logic              flush,
    output fctrl_t            fctrl,
    output logic [LVL_W-1:0]  thr_d
);
    fctrl_t fctrl_d;
    logic   ctrl_we, full, empty, rx_zero;

    assign ctrl_we   = we && (waddr == OFS_FCTRL);
    assign push      = we && (waddr == OFS_WDATA);
    assign push_byte = wdata[DATA_W-1:0];
    assign flush     = ctrl_we && wdata[1];
    assign fctrl_d   = ctrl_we ? fctrl_t'({wdata[6:5], wdata[4:2]}) : fctrl;
    assign thr_d     = LVL_W'(thr_of(fctrl_d.tx_code));

    always_ff @(posedge clk) begin
        if (rst) fctrl <= '0;
        else     fctrl <= fctrl_d;
    end

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign rx_zero = (rx_level == '0);

    always_comb begin
        rdata = '0;
        case (raddr)
            OFS_STATUS: rdata[5:0] = {rx_zero, rx_zero, 1'b1, empty, 1'b0, full};
            OFS_FCTRL:  rdata[6:2] = {fctrl.tx_code, fctrl.rx_code};
            OFS_FSTAT: begin
                rdata[4:0]   = level[4:0];
                rdata[20:16] = rx_level;
            end
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/tx_fifo_wm.sv
module tx_fifo_wm
    import txq_pkg::*;
#(
    parameter int unsigned DEPTH = 32,
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [7:0]        reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [7:0]        reg_raddr,
    output logic [31:0]       reg_rdata,
    input  logic [4:0]        rx_level,
    input  logic              tx_en,
    input  logic              tx_pop,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              evt_tx_wm,
    output logic              evt_tx_empty
);
    logic             push, flush, pop;
    logic [7:0]       push_byte;
    logic [LVL_W-1:0] level, level_d, thr_d;
    fctrl_t           fctrl;

    assign pop = tx_en && tx_pop;

    txq_regs #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .level(level), .rx_level(rx_level), .rdata(reg_rdata),
        .push(push), .push_byte(push_byte), .flush(flush), .fctrl(fctrl), .thr_d(thr_d)
    );

    txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .flush(flush),
        .din(push_byte), .dout(tx_byte), .level(level), .level_d(level_d)
    );

    txq_flags #(.LVL_W(LVL_W)) u_flags (
        .clk(clk), .rst(rst), .flush(flush), .level(level), .level_d(level_d),
        .thr_d(thr_d), .evt_wm(evt_tx_wm), .evt_empty(evt_tx_empty)
    );

    assign tx_valid = (level != '0);
    assign tx_full  = (level == LVL_W'(DEPTH));
    assign tx_empty = (level == '0);

    assert_wm_track_R6: assert property (@(posedge clk) disable iff (rst)
        evt_tx_wm == (level >= LVL_W'(thr_of(fctrl.tx_code))));

    assert_empty_evt_R7: assert property (@(posedge clk) disable iff (rst)
        evt_tx_empty |-> (level == '0 && $past(level) == LVL_W'(1)));

    assert_no_pop_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && !reg_we) |=> $stable(level));

endmodule

// File: tb/tx_fifo_wm_tb.sv
module tx_fifo_wm_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [7:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic [4:0]  rx_level = '0;
    logic        tx_en = 1'b0, tx_pop = 1'b0;
    logic        tx_valid, tx_full, tx_empty, evt_tx_wm, evt_tx_empty;
    logic [7:0]  tx_byte;
    int n_run = 0, n_fail = 0;

    always #10 clk = ~clk;

    tx_fifo_wm u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .rx_level(rx_level), .tx_en(tx_en),
        .tx_pop(tx_pop), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_full(tx_full),
        .tx_empty(tx_empty), .evt_tx_wm(evt_tx_wm), .evt_tx_empty(evt_tx_empty)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_raddr = a; #1; d = reg_rdata;
    endtask

    task automatic lvl(output logic [31:0] l);
        logic [31:0] s, f;
        rd(8'h24, f); rd(8'h14, s);
        l = s[0] ? 32 : {27'b0, f[4:0]};
    endtask

    // one cycle: optional write, optional pop request
    task automatic cyc(input logic we, input logic [7:0] a, input logic [31:0] d,
                       input logic en, input logic pp);
        @(negedge clk);
        reg_we = we; reg_waddr = a; reg_wdata = d; tx_en = en; tx_pop = pp;
        @(posedge clk); #1;
        reg_we = 1'b0; tx_pop = 1'b0; tx_en = 1'b0;
    endtask

    task automatic push(input logic [7:0] b); cyc(1, 8'h1C, {24'hABCDEF, b}, 0, 0); endtask
    task automatic pop1();                    cyc(0, 8'h00, 0, 1, 1);                endtask
    task automatic flushq();                  cyc(1, 8'h20, 32'h2, 0, 0);           endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(8'h14, d); chk("R3 reset status", d, 32'h3C);
        rd(8'h20, d); chk("R4 reset fctrl", d, 0);
        rd(8'h24, d); chk("R8 reset fstat", d, 0);
        chk("R6 reset wm", evt_tx_wm, 0);
    endtask

    task automatic t_order();
        logic [31:0] l;
        push(8'h11); push(8'h22); push(8'h33);
        lvl(l); chk("R1 level 3", l, 3);
        chk("R1 head", tx_byte, 8'h11); chk("R1 valid", tx_valid, 1);
        pop1(); chk("R1 second", tx_byte, 8'h22);
        pop1(); chk("R1 third", tx_byte, 8'h33);
        pop1(); lvl(l); chk("R1 drained", l, 0);
    endtask

    task automatic t_full();
        logic [31:0] l, d;
        for (int i = 0; i < 32; i++) push(8'(i + 8'h40));
        rd(8'h14, d); chk("R3 full status", d, 32'h39);
        rd(8'h24, d); chk("R8 level 32 field", d, 0);
        push(8'hEE); lvl(l); chk("R2 drop level", l, 32);
        chk("R2 head intact", tx_byte, 8'h40);
        cyc(1, 8'h1C, 32'hEE, 1, 1); lvl(l); chk("R2 drop with pop", l, 31);
        for (int i = 1; i < 32; i++) begin
            if (tx_byte !== 8'(i + 8'h40)) chk("R2 contents", tx_byte, 8'(i + 8'h40));
            pop1();
        end
        chk("R2 empty after drain", tx_empty, 1);
    endtask

    task automatic t_flush();
        logic [31:0] l;
        push(1); push(2); push(3);
        cyc(1, 8'h20, 32'h2, 1, 1); lvl(l);
        chk("R5 flush level", l, 0);
        chk("R7 no empty evt on flush", evt_tx_empty, 0);
    endtask

    task automatic t_wm();
        logic [31:0] d;
        cyc(1, 8'h20, 32'h20 | 32'h1C, 0, 0);
        rd(8'h20, d); chk("R4 readback", d, 32'h3C);
        push(1); push(2); push(3);
        chk("R6 wm below 4", evt_tx_wm, 0);
        push(4); chk("R6 wm at 4", evt_tx_wm, 1);
        pop1(); chk("R6 wm drop below 4", evt_tx_wm, 0);
        cyc(1, 8'h20, 32'h0, 0, 0); chk("R6 code0 thr1", evt_tx_wm, 1);
        cyc(1, 8'h20, 32'h40, 0, 0); chk("R6 code2 thr8", evt_tx_wm, 0);
        for (int i = 0; i < 5; i++) push(8'(i));
        chk("R6 level 8 at thr8", evt_tx_wm, 1);
        flushq(); chk("R6 wm clear on flush", evt_tx_wm, 0);
    endtask

    task automatic t_empty_evt();
        push(8'h5A); push(8'h5B);
        pop1(); chk("R7 no pulse at 1", evt_tx_empty, 0);
        pop1(); chk("R7 pulse", evt_tx_empty, 1); chk("R7 empty status", tx_empty, 1);
        cyc(0, 0, 0, 0, 0); chk("R7 one cycle", evt_tx_empty, 0);
    endtask

    task automatic t_simul_and_enable();
        logic [31:0] l;
        push(8'hA1); push(8'hA2);
        cyc(1, 8'h1C, 32'hA3, 1, 1); lvl(l);
        chk("R10 level unchanged", l, 2); chk("R10 order", tx_byte, 8'hA2);
        cyc(0, 0, 0, 0, 1); lvl(l); chk("R9 no pop when disabled", l, 2);
        cyc(0, 0, 0, 1, 0); lvl(l); chk("R9 no pop without request", l, 2);
        pop1(); chk("R10 tail", tx_byte, 8'hA3);
        flushq();
    endtask

    task automatic t_misc();
        logic [31:0] d, l;
        rx_level = 5'd9; push(8'h01);
        rd(8'h24, d); chk("R8 rx and tx level", d, 32'h0009_0001);
        rd(8'h14, d); chk("R3 rx nonzero status", d, 32'h08);
        rd(8'h18, d); chk("R11 unmapped read", d, 0);
        cyc(1, 8'h28, 32'hFF, 0, 0); lvl(l); chk("R11 unmapped write level", l, 1);
        rd(8'h20, d); chk("R11 fctrl untouched", d, 0);
        rx_level = 0; flushq();
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_order();
        t_full();
        t_flush();
        t_wm();
        t_empty_evt();
        t_simul_and_enable();
        t_misc();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule